// File: doc/BRIEF.md
# Word Block Clear and Copy Engine

This engine carries out two block operations for a 16-bit processor on a single-port synchronous word memory. A clear operation writes zero into a run of consecutive words. A copy operation moves a run of consecutive words from one region to another. In both operations the processor's accumulator values supply the start addresses. The first accumulator value gives the clear base or the copy source. The second accumulator value gives the copy destination. The instruction supplies the word count, which must lie between 1 and 16.

The processor presents the opcode, the count and both accumulator values, then raises a start strobe for one cycle. The engine then owns the memory port until the last write is done. A clear writes one word per cycle. A copy spends two cycles per word, because the single memory port allows only one access per cycle: a read cycle, then a write cycle that stores the returned data. Every copy runs from low addresses to high ones, including copies between overlapping regions. A count outside the legal range is refused with a one-cycle error pulse, and the memory is not touched.

Top module: `blkmove_engine`

## Requirements
- R1: While reset is held and in the first cycle after its release, `busy`, `done`, `error`, `mem_we` and `mem_re` are all low.
- R2: With `cmd_op` = 0 (clear), the engine writes the value 0 to `cmd_count` words at ascending addresses, starting at `cmd_src[14:0]`. It writes one word per cycle, and `busy` is high for exactly `cmd_count` cycles.
- R3: With `cmd_op` = 1 (copy), the engine copies `cmd_count` words from ascending addresses starting at `cmd_src[14:0]` to ascending addresses starting at `cmd_dst[14:0]`. For each word it spends one read cycle (`mem_re`), then one write cycle (`mem_we`), and `busy` is high for exactly 2×`cmd_count` cycles.
- R4: Counts from 1 to 16 inclusive are accepted, and both ends of that range run to completion. `cmd_count` is a 6-bit field.
- R5: A start with `cmd_count` equal to 0 or greater than 16 raises `error` for exactly the one cycle that follows the start edge. In that case there is no memory access, `busy` does not rise and `done` does not rise.
- R6: Addresses are the low 15 bits of the start values, and bit 15 is ignored. Pointers wrap from 0x7FFF to 0x0000.
- R7: A copy always runs forward. With overlapping regions where the destination lies above the source, the memory ends up exactly as a word-by-word forward loop would leave it, so earlier data propagates.
- R8: `done` is high for exactly one cycle, in the cycle right after the last busy cycle, and `busy` is low during that cycle.
- R9: A start is acted on only when both `busy` and `done` are low. A start in any other cycle causes no memory access and does not change the running operation.
- R10: A clear ignores `cmd_dst`, and it never raises `mem_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_start | input | 1 | One-cycle command strobe |
| cmd_op | input | 1 | 0 = clear, 1 = copy |
| cmd_count | input | 6 | Word count (legal range 1 to 16) |
| cmd_src | input | 16 | First accumulator: clear base or copy source |
| cmd_dst | input | 16 | Second accumulator: copy destination |
| mem_addr | output | 15 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable; data returns on the next cycle |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, registered by the memory |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle pulse for a rejected count |

## Verification
After the start edge, `busy` is high at the very next sample. It then stays high for N cycles for a clear or 2N cycles for a copy, and `done` appears in the single cycle after that. `error` is due only in the one cycle after a start with an illegal count. Inputs are driven, and outputs sampled, on the falling edge, so each sample reflects the registers loaded at the preceding rising edge. The bench counts the busy cycles from the first sample after the start up to the sample where `done` is high, and it checks the exact count of cycles. It also logs every write address and compares the log and the final memory contents with a forward-loop model.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLEAR = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_DONE  = 3'd4
  } bm_state_t;

  typedef enum logic {
    OP_CLEAR = 1'b0,
    OP_COPY  = 1'b1
  } bm_op_t;

endpackage

// File: rtl/blkmove_range_chk.sv
module blkmove_range_chk #(
  parameter int CNT_W     = 6,
  parameter int MAX_WORDS = 16
) (
  input  logic [CNT_W-1:0] count,
  output logic             count_ok
);

  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_WORDS);

  always_comb begin
    count_ok = (count != '0) && (count <= MAX_CNT);
  end

endmodule

// File: rtl/blkmove_ptr_unit.sv
module blkmove_ptr_unit #(
  parameter int ADDR_W = 15,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_src,
  input  logic [ADDR_W-1:0] load_dst,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              step_src,
  input  logic              step_dst,
  input  logic              step_cnt,
  output logic [ADDR_W-1:0] src_ptr,
  output logic [ADDR_W-1:0] dst_ptr,
  output logic [CNT_W-1:0]  remaining,
  output logic              last
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  logic [ADDR_W-1:0] src_q, src_d;
  logic [ADDR_W-1:0] dst_q, dst_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              src_en, dst_en, cnt_en;

  always_comb begin
    src_en = load | step_src;
    dst_en = load | step_dst;
    cnt_en = load | step_cnt;
    src_d  = load ? load_src : (src_q + ADDR_ONE);
    dst_d  = load ? load_dst : (dst_q + ADDR_ONE);
    cnt_d  = load ? load_cnt : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else begin
      if (src_en) src_q <= src_d;
      if (dst_en) dst_q <= dst_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign remaining = cnt_q;
  assign last      = (cnt_q == CNT_ONE);

  // R4
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt |-> (remaining != '0));

  // R6
  src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_src && !load) |=> (src_ptr == $past(src_ptr) + ADDR_ONE));

endmodule

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic op_copy,
  input  logic cnt_ok,
  input  logic last,
  output logic load,
  output logic step_src,
  output logic step_dst,
  output logic step_cnt,
  output logic mem_we,
  output logic mem_re,
  output logic sel_dst,
  output logic wr_zero,
  output logic busy,
  output logic done,
  output logic error
);

  bm_state_t state_q, state_d;
  logic      err_q, err_d;
  logic      accept;

  always_comb begin
    accept   = start && (state_q == ST_IDLE);
    load     = accept && cnt_ok;
    err_d    = accept && !cnt_ok;
    state_d  = state_q;
    step_src = 1'b0;
    step_dst = 1'b0;
    step_cnt = 1'b0;
    mem_we   = 1'b0;
    mem_re   = 1'b0;
    sel_dst  = 1'b0;
    wr_zero  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (load) state_d = op_copy ? ST_READ : ST_CLEAR;
      end
      ST_CLEAR: begin
        mem_we   = 1'b1;
        wr_zero  = 1'b1;
        step_src = 1'b1;
        step_cnt = 1'b1;
        if (last) state_d = ST_DONE;
      end
      ST_READ: begin
        mem_re   = 1'b1;
        step_src = 1'b1;
        state_d  = ST_WRITE;
      end
      ST_WRITE: begin
        mem_we   = 1'b1;
        sel_dst  = 1'b1;
        step_dst = 1'b1;
        step_cnt = 1'b1;
        state_d  = last ? ST_DONE : ST_READ;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign busy  = (state_q == ST_CLEAR) || (state_q == ST_READ) || (state_q == ST_WRITE);
  assign done  = (state_q == ST_DONE);
  assign error = err_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (!busy && !mem_we && !mem_re));

  // R3
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (mem_we && sel_dst));

  // R9
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> busy);

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine #(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 15,
  parameter int CNT_W     = 6,
  parameter int MAX_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic              cmd_op,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [DATA_W-1:0] cmd_src,
  input  logic [DATA_W-1:0] cmd_dst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic              error
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic              count_ok;
  logic              load, step_src, step_dst, step_cnt;
  logic              sel_dst, wr_zero, last;
  logic [ADDR_W-1:0] src_ptr, dst_ptr;
  logic [CNT_W-1:0]  remaining;

  blkmove_range_chk #(
    .CNT_W     (CNT_W),
    .MAX_WORDS (MAX_WORDS)
  ) u_range (
    .count    (cmd_count),
    .count_ok (count_ok)
  );

  blkmove_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_start),
    .op_copy  (cmd_op),
    .cnt_ok   (count_ok),
    .last     (last),
    .load     (load),
    .step_src (step_src),
    .step_dst (step_dst),
    .step_cnt (step_cnt),
    .mem_we   (mem_we),
    .mem_re   (mem_re),
    .sel_dst  (sel_dst),
    .wr_zero  (wr_zero),
    .busy     (busy),
    .done     (done),
    .error    (error)
  );

  blkmove_ptr_unit #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W)
  ) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_src  (cmd_src[ADDR_W-1:0]),
    .load_dst  (cmd_dst[ADDR_W-1:0]),
    .load_cnt  (cmd_count),
    .step_src  (step_src),
    .step_dst  (step_dst),
    .step_cnt  (step_cnt),
    .src_ptr   (src_ptr),
    .dst_ptr   (dst_ptr),
    .remaining (remaining),
    .last      (last)
  );

  always_comb begin
    mem_addr  = sel_dst ? dst_ptr : src_ptr;
    mem_wdata = wr_zero ? '0 : mem_rdata;
  end

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_ONE));

  // R10
  clear_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> !$past(mem_re));

endmodule

// File: tb/blkmove_engine_tb.sv
module blkmove_engine_tb;

  localparam int MW = 256;

  logic        clk;
  logic        rst_n;
  logic        cmd_start;
  logic        cmd_op;
  logic [5:0]  cmd_count;
  logic [15:0] cmd_src;
  logic [15:0] cmd_dst;
  logic [14:0] mem_addr;
  logic        mem_we;
  logic        mem_re;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        busy;
  logic        done;
  logic        error;

  logic [15:0] bmem   [MW];
  logic [15:0] refmem [MW];
  logic [14:0] wlog   [64];
  int          wcnt;
  int          checks;
  int          fails;
  int          cycles;

  blkmove_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_op    (cmd_op),
    .cmd_count (cmd_count),
    .cmd_src   (cmd_src),
    .cmd_dst   (cmd_dst),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .done      (done),
    .error     (error)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_we) begin
      bmem[mem_addr[7:0]] <= mem_wdata;
      wlog[wcnt % 64]     <= mem_addr;
      wcnt                <= wcnt + 1;
    end
    if (mem_re) mem_rdata <= bmem[mem_addr[7:0]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        finish_run();
      end
    end
  end

  function automatic void model_clear(input int a, input int n);
    for (int i = 0; i < n; i++) refmem[(a + i) % MW] = 16'h0000;
  endfunction

  function automatic void model_copy(input int s, input int d, input int n);
    for (int i = 0; i < n; i++) refmem[(d + i) % MW] = refmem[(s + i) % MW];
  endfunction

  task automatic mem_compare(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < MW; i++) begin
      if (bmem[i] !== refmem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, first, -1);
  endtask

  // Runs one legal command; inject=1 also strobes extra starts while busy and during done (R9)
  task automatic run_op(input bit op, input int n, input logic [15:0] s,
                        input logic [15:0] d, input bit inject, input string req);
    int base = wcnt;
    int cyc = 0;
    int exp_cyc = op ? 2 * n : n;
    int base_w = op ? int'(d[14:0]) : int'(s[14:0]);
    cmd_op = op; cmd_count = 6'(n); cmd_src = s; cmd_dst = d; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    while (!done && cyc < 100) begin
      if (busy) cyc++;
      if (inject && cyc == 2) begin
        cmd_start = 1'b1; cmd_op = ~op; cmd_count = 6'd3;
        cmd_src = 16'h0040; cmd_dst = 16'h0050;
      end else begin
        cmd_start = 1'b0;
      end
      @(negedge clk);
    end
    cmd_start = 1'b0;
    chk(cyc == exp_cyc, op ? "R3 busy cycles" : "R2 busy cycles", cyc, exp_cyc);
    chk(done && !busy, "R8 done with busy low", {done, busy}, 2);
    if (inject) begin
      cmd_start = 1'b1; cmd_op = 1'b0; cmd_count = 6'd2; cmd_src = 16'h0060;
    end
    @(negedge clk);
    cmd_start = 1'b0;
    chk(!done, "R8 done single cycle", done, 0);
    if (inject) chk(!busy, "R9 start during done ignored", busy, 0);
    chk((wcnt - base) == n, "R4 write count", wcnt - base, n);
    for (int i = 0; i < n; i++) begin
      int ea = (base_w + i) % 32768;
      chk(int'(wlog[(base + i) % 64]) == ea, "R6 write address", int'(wlog[(base + i) % 64]), ea);
    end
    if (op) model_copy(int'(s[7:0]), int'(d[7:0]), n); else model_clear(int'(s[7:0]), n);
    mem_compare(req);
  endtask

  task automatic run_bad(input int n);
    int base = wcnt;
    cmd_op = 1'b1; cmd_count = 6'(n); cmd_src = 16'h0010; cmd_dst = 16'h0020; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    chk(error && !busy, "R5 error pulse", {error, busy}, 2);
    @(negedge clk);
    chk(!error && !busy && !done, "R5 error one cycle", {error, busy, done}, 0);
    chk(wcnt == base, "R5 no write", wcnt - base, 0);
    mem_compare("R5 memory untouched");
  endtask

  initial begin
    void'($urandom(32'd2024));
    checks = 0; fails = 0; cycles = 0; wcnt = 0;
    cmd_start = 1'b0; cmd_op = 1'b0; cmd_count = '0; cmd_src = '0; cmd_dst = '0;
    for (int i = 0; i < MW; i++) begin
      logic [15:0] v = 16'($urandom);
      bmem[i] = v; refmem[i] = v;
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !error && !mem_we && !mem_re, "R1 reset outputs",
        {busy, done, error, mem_we, mem_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !error && !mem_we && !mem_re, "R1 after release",
        {busy, done, error, mem_we, mem_re}, 0);

    run_op(1'b0, 1,  16'h0005, 16'h0000, 1'b0, "R2 clear one word");
    run_op(1'b0, 16, 16'h8020, 16'hFFFF, 1'b0, "R10 clear sixteen, dst ignored");
    run_op(1'b1, 1,  16'h0030, 16'h0070, 1'b0, "R3 copy one word");
    run_op(1'b1, 16, 16'h0080, 16'h00A0, 1'b0, "R4 copy sixteen");
    run_op(1'b1, 8,  16'h00C0, 16'h00C2, 1'b0, "R7 forward overlap");
    run_op(1'b1, 6,  16'h00D2, 16'h00D0, 1'b0, "R7 backward overlap");
    run_op(1'b0, 4,  16'h7FFE, 16'h0000, 1'b0, "R6 clear wrap");
    run_op(1'b1, 5,  16'hFFFD, 16'h7FFE, 1'b0, "R6 copy wrap");
    run_op(1'b1, 6,  16'h0010, 16'h0090, 1'b1, "R9 start while busy ignored");
    run_bad(0);
    run_bad(17);
    run_bad(63);

    for (int k = 0; k < 40; k++) begin
      bit          op = 1'($urandom);
      int          n  = 1 + int'($urandom % 16);
      logic [15:0] s  = 16'($urandom);
      logic [15:0] d  = 16'($urandom);
      if (($urandom % 8) == 0) run_bad(17 + int'($urandom % 47));
      run_op(op, n, s, d, 1'($urandom % 4 == 0), op ? "R3 random copy" : "R2 random clear");
    end

    finish_run();
  end

endmodule